// File: doc/BRIEF.md
# Long Conditional Branch Evaluator

The block decides whether a conditional branch with a 16-bit offset is taken. It also produces the next program counter and the cycle cost of the branch. A 4-bit condition selector from the opcode is applied to the four status flags N, Z, V and C. The program counter arrives pointing at the first byte of the offset field, and the offset itself is a signed 16-bit value. The front end that fetches the opcode and the offset bytes sits outside the block.

The result is registered. One cycle after `in_valid` is high, `out_valid` pulses together with the decision, the next PC and the cycle count. The two-byte skip of the offset field always applies. The sign-extended offset is added on top only when the branch is taken. The cycle cost is a base cost plus one when taken. The base cost is 5, except for the carry-clear condition, whose base cost is 6.

Top module: `lbranch_eval`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `taken`, `next_pc` and `cycles` are all 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The outputs of that cycle belong to the inputs sampled at that edge.
- R3: When the branch is not taken, `next_pc` = `pc` + 2 modulo 2^16.
- R4: When the branch is taken, `next_pc` = `pc` + 2 + sign-extended `offset`, modulo 2^16.
- R5: Selector 0x1 (never) is never taken, and the 2-byte skip still applies. Selector 0x0 (always) is always taken. `flags` is laid out as bit3=N, bit2=Z, bit1=V, bit0=C.
- R6: Selector 0x2 (higher) is taken when C=0 and Z=0. Selector 0x3 (lower-or-same) is taken when C=1 or Z=1.
- R7: Selector 0x4 (carry clear) is taken when C=0. Selector 0x5 (carry set) is taken when C=1.
- R8: The single-flag selectors are taken as follows:
   - 0x6 when Z=0 and 0x7 when Z=1.
   - 0x8 when V=0 and 0x9 when V=1.
   - 0xA when N=0 and 0xB when N=1.
- R9: Selector 0xC is taken when N XNOR V is 1. Selector 0xD is taken when N XOR V is 1.
- R10: Selector 0xE is taken when NOT(Z OR (N XOR V)) is 1. Selector 0xF is taken when Z OR (N XOR V) is 1.
- R11: `cycles` = 5 + taken for every selector except 0x4. For selector 0x4, `cycles` = 6 + taken.
- R12: PC arithmetic wraps. A PC near 0xFFFF or a large negative offset wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs are presented this cycle |
| cond | input | 4 | Condition selector from the opcode |
| flags | input | 4 | {N, Z, V, C} |
| pc | input | 16 | PC pointing at the offset field |
| offset | input | 16 | Signed branch offset |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Next program counter |
| cycles | output | 4 | Cycle cost of the branch |

## Verification
Every selector is crossed with all sixteen flag combinations. This separates each condition from its complement and from the other conditions that share a flag. For example, higher, carry clear and greater-than each respond to a different subset of flags. Positive, negative and zero offsets tell the taken target apart from the fall-through address. Vectors with a PC near 0xFFFF and with a large negative offset catch a missing 16-bit wrap. The carry-clear cost is checked in both its taken and not-taken forms against the other selectors, which shows that the extra base cycle is tied to that one selector.

// File: rtl/lbranch_pkg.sv
package lbranch_pkg;
   // selector pairs: index = cond[3:1], cond[0] inverts the pair's base test
   typedef enum logic [2:0] {
      PAIR_ALWAYS = 3'd0,
      PAIR_HIGHER = 3'd1,
      PAIR_CCLEAR = 3'd2,
      PAIR_ZCLEAR = 3'd3,
      PAIR_VCLEAR = 3'd4,
      PAIR_NCLEAR = 3'd5,
      PAIR_SGE    = 3'd6,
      PAIR_SGT    = 3'd7
   } pair_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

   localparam logic [3:0] SEL_CARRY_CLEAR = 4'h4;
endpackage

// File: rtl/lbranch_cond.sv
module lbranch_cond
   import lbranch_pkg::*;
(
   input  logic [3:0] cond,
   input  flags_t     flags,
   output logic       taken
);
   localparam int NPAIRS = 8;

   logic [NPAIRS-1:0] base_test;

   always_comb begin
      base_test              = '0;
      base_test[PAIR_ALWAYS] = 1'b1;
      base_test[PAIR_HIGHER] = ~(flags.c | flags.z);
      base_test[PAIR_CCLEAR] = ~flags.c;
      base_test[PAIR_ZCLEAR] = ~flags.z;
      base_test[PAIR_VCLEAR] = ~flags.v;
      base_test[PAIR_NCLEAR] = ~flags.n;
      base_test[PAIR_SGE]    = ~(flags.n ^ flags.v);
      base_test[PAIR_SGT]    = ~(flags.z | (flags.n ^ flags.v));
   end

   assign taken = base_test[cond[3:1]] ^ cond[0];
endmodule

// File: rtl/lbranch_target.sv
module lbranch_target #(
   parameter int ADDR_W    = 16,
   parameter int OFS_W     = 16,
   parameter int OFS_BYTES = 2
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [OFS_W-1:0]  offset,
   input  logic              taken,
   output logic [ADDR_W-1:0] next_pc
);
   localparam int EXT_W = ADDR_W - OFS_W;

   logic [ADDR_W-1:0] skip_pc;
   logic [ADDR_W-1:0] ofs_ext;

   generate
      if (EXT_W > 0) begin : g_ext
         assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
      end else begin : g_noext
         assign ofs_ext = offset[ADDR_W-1:0];
      end
   endgenerate

   assign skip_pc = pc + ADDR_W'(OFS_BYTES);
   assign next_pc = taken ? skip_pc + ofs_ext : skip_pc;
endmodule

// File: rtl/lbranch_cost.sv
module lbranch_cost
   import lbranch_pkg::*;
#(
   parameter int CYC_W    = 4,
   parameter int BASE_CYC = 5,
   parameter int HS_CYC   = 6
) (
   input  logic [3:0]       cond,
   input  logic             taken,
   output logic [CYC_W-1:0] cycles
);
   logic [CYC_W-1:0] base;

   assign base   = (cond == SEL_CARRY_CLEAR) ? CYC_W'(HS_CYC) : CYC_W'(BASE_CYC);
   assign cycles = base + CYC_W'(taken);
endmodule

// File: rtl/lbranch_eval.sv
module lbranch_eval
   import lbranch_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int OFS_W     = 16,
   parameter int OFS_BYTES = 2,
   parameter int CYC_W     = 4,
   parameter int BASE_CYC  = 5,
   parameter int HS_CYC    = 6,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [3:0]        cond,
   input  logic [3:0]        flags,
   input  logic [ADDR_W-1:0] pc,
   input  logic [OFS_W-1:0]  offset,
   output logic              out_valid,
   output logic              taken,
   output logic [ADDR_W-1:0] next_pc,
   output logic [CYC_W-1:0]  cycles
);
   localparam int MAX_CYC = ((HS_CYC > BASE_CYC) ? HS_CYC : BASE_CYC) + 1;

   generate
      if (OFS_W > ADDR_W) begin : g_bad_ofs
         $error("lbranch_eval: OFS_W must not exceed ADDR_W");
      end
      if (MAX_CYC >= (1 << CYC_W)) begin : g_bad_cyc
         $error("lbranch_eval: CYC_W too narrow for cycle count");
      end
   endgenerate

   logic              c_taken;
   logic [ADDR_W-1:0] c_next;
   logic [CYC_W-1:0]  c_cycles;
   flags_t            f;

   assign f = flags_t'(flags);

   lbranch_cond u_cond (
      .cond  (cond),
      .flags (f),
      .taken (c_taken)
   );

   lbranch_target #(
      .ADDR_W    (ADDR_W),
      .OFS_W     (OFS_W),
      .OFS_BYTES (OFS_BYTES)
   ) u_target (
      .pc      (pc),
      .offset  (offset),
      .taken   (c_taken),
      .next_pc (c_next)
   );

   lbranch_cost #(
      .CYC_W    (CYC_W),
      .BASE_CYC (BASE_CYC),
      .HS_CYC   (HS_CYC)
   ) u_cost (
      .cond   (cond),
      .taken  (c_taken),
      .cycles (c_cycles)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               out_valid <= 1'b0;
               taken     <= 1'b0;
               next_pc   <= '0;
               cycles    <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  taken   <= c_taken;
                  next_pc <= c_next;
                  cycles  <= c_cycles;
               end
            end
         end
      end else begin : g_comb
         assign out_valid = in_valid & ~rst;
         assign taken     = c_taken;
         assign next_pc   = c_next;
         assign cycles    = c_cycles;
      end
   endgenerate
endmodule

// File: rtl/lbranch_eval_chk.sv
module lbranch_eval_chk #(
   parameter int ADDR_W    = 16,
   parameter int OFS_W     = 16,
   parameter int OFS_BYTES = 2,
   parameter int CYC_W     = 4,
   parameter int BASE_CYC  = 5,
   parameter int HS_CYC    = 6,
   parameter bit REG_OUT   = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [3:0]        cond,
   input logic [ADDR_W-1:0] pc,
   input logic              out_valid,
   input logic              taken,
   input logic [ADDR_W-1:0] next_pc,
   input logic [CYC_W-1:0]  cycles
);
   generate
      if (REG_OUT) begin : g_chk
         AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid); // R2
         AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid); // R2
         AST_FALLTHRU_PC: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !taken) |-> next_pc == $past(pc) + ADDR_W'(OFS_BYTES)); // R3
         AST_NEVER_FORM: assert property (@(posedge clk) disable iff (rst)
            (out_valid && $past(cond) == 4'h1) |-> !taken); // R5
         AST_ALWAYS_FORM: assert property (@(posedge clk) disable iff (rst)
            (out_valid && $past(cond) == 4'h0) |-> taken); // R5
         AST_CYCLE_COST: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> cycles == (($past(cond) == 4'h4) ? CYC_W'(HS_CYC) : CYC_W'(BASE_CYC))
                                    + CYC_W'(taken)); // R11
      end
   endgenerate
endmodule

bind lbranch_eval lbranch_eval_chk #(
   .ADDR_W    (ADDR_W),
   .OFS_W     (OFS_W),
   .OFS_BYTES (OFS_BYTES),
   .CYC_W     (CYC_W),
   .BASE_CYC  (BASE_CYC),
   .HS_CYC    (HS_CYC),
   .REG_OUT   (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .cond      (cond),
   .pc        (pc),
   .out_valid (out_valid),
   .taken     (taken),
   .next_pc   (next_pc),
   .cycles    (cycles)
);

// File: tb/lbranch_eval_test.sv
`timescale 1ns/1ps
module lbranch_eval_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [3:0]  cond = '0;
   logic [3:0]  flags = '0;
   logic [15:0] pc = '0;
   logic [15:0] offset = '0;
   logic        out_valid;
   logic        taken;
   logic [15:0] next_pc;
   logic [3:0]  cycles;

   always #2 clk = ~clk;

   lbranch_eval uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .cond      (cond),
      .flags     (flags),
      .pc        (pc),
      .offset    (offset),
      .out_valid (out_valid),
      .taken     (taken),
      .next_pc   (next_pc),
      .cycles    (cycles)
   );

   typedef struct {
      logic        tk;
      logic [15:0] npc;
      logic [3:0]  cyc;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   int   pushed = 0;
   int   popped = 0;
   bit   done = 0;

   function automatic logic model_taken(input logic [3:0] c, input logic [3:0] f);
      logic n, z, v, cy;
      n = f[3]; z = f[2]; v = f[1]; cy = f[0];
      case (c)
         4'h0: return 1'b1;
         4'h1: return 1'b0;
         4'h2: return !cy && !z;
         4'h3: return cy || z;
         4'h4: return !cy;
         4'h5: return cy;
         4'h6: return !z;
         4'h7: return z;
         4'h8: return !v;
         4'h9: return v;
         4'hA: return !n;
         4'hB: return n;
         4'hC: return n == v;
         4'hD: return n != v;
         4'hE: return !z && (n == v);
         default: return z || (n != v);
      endcase
   endfunction

   function automatic string cond_req(input logic [3:0] c);
      case (c)
         4'h0, 4'h1: return "R5";
         4'h2, 4'h3: return "R6";
         4'h4, 4'h5: return "R7";
         4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB: return "R8";
         4'hC, 4'hD: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // driver: presents one vector on a negedge and queues the expected result
   task automatic drive(input logic [3:0] c, input logic [3:0] f,
                        input logic [15:0] p, input logic [15:0] o, input string preq);
      exp_t e;
      e.tk  = model_taken(c, f);
      e.npc = e.tk ? 16'(p + 16'd2 + o) : 16'(p + 16'd2);
      e.cyc = 4'((c == 4'h4) ? 6 : 5) + 4'(e.tk);
      e.req = preq;
      exp_q.push_back(e);
      pushed++;
      in_valid = 1'b1; cond = c; flags = f; pc = p; offset = o;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: pops an expected item for every result
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check("R2", "unexpected out_valid", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               popped++;
               check(cond_req(4'(0)) == "" ? e.req : e.req, "taken", int'(taken), int'(e.tk));
               check(e.tk ? "R4" : "R3", "next_pc", int'(next_pc), int'(e.npc));
               check("R11", "cycles", int'(cycles), int'(e.cyc));
            end
         end
      end
   end

   initial begin : watchdog
      #400000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "out_valid in reset", int'(out_valid), 0);
      check("R1", "taken in reset", int'(taken), 0);
      check("R1", "next_pc in reset", int'(next_pc), 0);
      check("R1", "cycles in reset", int'(cycles), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1", "out_valid after reset", int'(out_valid), 0);
      check("R1", "cycles after reset", int'(cycles), 0);

      // every selector against every flag combination
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 16; f++) begin
            drive(4'(c), 4'(f), 16'h1000 + 16'(c * 16 + f), (f[0]) ? 16'hFF80 : 16'h0123,
                  cond_req(4'(c)));
         end
      end
      // wrap cases R12
      drive(4'h0, 4'h0, 16'hFFFE, 16'h0005, "R12");
      drive(4'h1, 4'h0, 16'hFFFF, 16'h0005, "R12");
      drive(4'h0, 4'h0, 16'h0010, 16'h8000, "R12");
      drive(4'h6, 4'h0, 16'hFFF0, 16'h0020, "R12");
      drive(4'h4, 4'h0, 16'h2000, 16'h0000, "R11");
      drive(4'h4, 4'h1, 16'h2000, 16'h0000, "R11");
      // back-to-back then idle gap R2
      drive(4'h7, 4'h4, 16'h3000, 16'hFFFE, "R8");
      @(negedge clk);
      check("R2", "out_valid idle", int'(out_valid), 0);
      repeat (2) @(negedge clk);
      check("R2", "results count", popped, pushed);
      check("R2", "queue empty", exp_q.size(), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule